// File: doc/BRIEF.md
# Interrupt Source Sense Gateway

The gateway keeps per-source interrupt state for a message-signalled interrupt domain with `NSRC` sources, numbered 1 to `NSRC`. Each source has a raw input wire, a stored sense mode, a stored (rectified) copy of its synchronized input, a pending bit and an enable bit. The sense mode decides whether a rising edge, a falling edge, a high level or a low level of the input makes the source pending, or whether the input is disregarded.

Software reaches the state through a simple write port (one operation per cycle, addressed by source number) and a combinational read port. When the domain-wide enable is on, any source that is both pending and enabled is forwarded. The lowest-numbered such source is forwarded first, one per cycle, and forwarding consumes its pending bit. Message formatting and bus decode are left to the surrounding logic, which consumes `fwd_valid`/`fwd_num`.

Top module: `irq_sense_gateway`

## Requirements
- R1: After reset every source reads back zero configuration, pending, enable and stored input, `dom_en` is 0 and `fwd_valid` is 0.
- R2: Valid source numbers are 1 to `NSRC`. A write to number 0 or to a number above `NSRC` changes no state, and a read of such a number returns zero on `rd_cfg`, `rd_pend`, `rd_ie` and `rd_in`.
- R3: A configuration write (op 0) with `wr_data[10]` set stores mode 0. Otherwise it stores `wr_data[2:0]`. The stored mode reads back on `rd_cfg[2:0]`, and `rd_cfg[31:3]` is zero.
- R4: Mode 4 (rising) sets pending when the synchronized input is 1 and the stored input is 0. Mode 5 (falling) sets pending when the synchronized input is 0 and the stored input is 1.
- R5: Mode 6 sets pending in every cycle the synchronized input is 1, and mode 7 in every cycle it is 0. Modes 0 (inactive), 1 (detached), 2 and 3 never set pending from the input.
- R6: Each input passes two synchronizer flops. The stored input then takes the synchronized level every cycle and reads back on `rd_in`. An input change makes a source pending after the third rising clock edge.
- R7: Write operations are selected by `wr_op`: 1 sets pending in every mode; 2 clears pending except in modes 6 and 7, where it has no effect; 3 sets enable; 4 clears enable; 5 loads `dom_en` from `wr_data[0]`, whatever the source number.
- R8: `fwd_valid` is high, in the same cycle, exactly when `dom_en` is 1 and at least one source is both pending and enabled.
- R9: `fwd_num` gives the lowest-numbered source that is both pending and enabled.
- R10: The forwarded source's pending bit is cleared at the next clock edge. A set of that pending bit in the same cycle, from the input or from software, takes precedence, so the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Raw interrupt inputs, bit k is source k+1 |
| wr_en | input | 1 | Write strobe |
| wr_op | input | 3 | Write operation code |
| wr_num | input | NUMW | Source number addressed by the write |
| wr_data | input | 32 | Write data (configuration or domain enable) |
| rd_num | input | NUMW | Source number addressed by the read |
| rd_cfg | output | 32 | Stored sense mode of the read source |
| rd_pend | output | 1 | Pending bit of the read source |
| rd_ie | output | 1 | Enable bit of the read source |
| rd_in | output | 1 | Stored input bit of the read source |
| dom_en | output | 1 | Domain-wide enable |
| fwd_valid | output | 1 | Forward request |
| fwd_num | output | NUMW | Source being forwarded |

## Verification
Forwarding a source and setting that same source's pending bit can happen in the same cycle. If they are resolved the wrong way, an interrupt is silently lost. The bench provokes this twice. First, it holds a level-high input active with forwarding on and requires `fwd_valid` to stay high on the same number in every cycle. Second, it times a rising edge to reach the sense logic in exactly the cycle that consumes a software-set pending bit, and requires two consecutive forwards followed by silence. Around these cases, mode sweeps over input transition pairs, and forwarding sweeps over pending/enable masks, judge each result against values the bench derives from the mode encoding.

// File: rtl/irq_sense_gateway.sv
`timescale 1ns/1ps
module irq_sense_gateway #(
  parameter int NSRC = 8,
  parameter int NUMW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            wr_en,
  input  logic [2:0]      wr_op,
  input  logic [NUMW-1:0] wr_num,
  input  logic [31:0]     wr_data,
  input  logic [NUMW-1:0] rd_num,
  output logic [31:0]     rd_cfg,
  output logic            rd_pend,
  output logic            rd_ie,
  output logic            rd_in,
  output logic            dom_en,
  output logic            fwd_valid,
  output logic [NUMW-1:0] fwd_num
);
  localparam logic [2:0] OP_CFG  = 3'd0;
  localparam logic [2:0] OP_SETP = 3'd1;
  localparam logic [2:0] OP_CLRP = 3'd2;
  localparam logic [2:0] OP_SETE = 3'd3;
  localparam logic [2:0] OP_CLRE = 3'd4;
  localparam logic [2:0] OP_DOM  = 3'd5;
  localparam logic [2:0] SM_RISE = 3'd4;
  localparam logic [2:0] SM_FALL = 3'd5;
  localparam logic [2:0] SM_HIGH = 3'd6;
  localparam logic [2:0] SM_LOW  = 3'd7;
  localparam int         DELEG   = 10;

  logic [NSRC-1:0]      sync1_q, sync2_q, lvl_q;
  logic [NSRC-1:0]      pend_q, pend_d, ie_q, ie_d;
  logic [NSRC-1:0][2:0] cfg_q, cfg_d;
  logic [NSRC-1:0]      elig, take;

  wire unused_bits = ^{wr_data[31:DELEG+1], wr_data[DELEG-1:3]};

  assign elig      = pend_q & ie_q & {NSRC{dom_en}};
  assign take      = elig & (~elig + NSRC'(1));
  assign fwd_valid = |elig;

  always_comb begin
    fwd_num = '0;
    for (int k = NSRC - 1; k >= 0; k--)
      if (elig[k]) fwd_num = NUMW'(k + 1);
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic hit, lvl_mode, sense, set_p, clr_p;

    assign hit      = wr_en && (wr_num == NUMW'(k + 1));
    assign lvl_mode = (cfg_q[k] == SM_HIGH) || (cfg_q[k] == SM_LOW);

    always_comb begin
      case (cfg_q[k])
        SM_RISE: sense = sync2_q[k] & ~lvl_q[k];
        SM_FALL: sense = ~sync2_q[k] & lvl_q[k];
        SM_HIGH: sense = sync2_q[k];
        SM_LOW:  sense = ~sync2_q[k];
        default: sense = 1'b0;
      endcase
    end

    assign set_p     = sense | (hit && wr_op == OP_SETP);
    assign clr_p     = take[k] | (hit && wr_op == OP_CLRP && !lvl_mode);
    assign pend_d[k] = set_p | (pend_q[k] & ~clr_p);
    assign ie_d[k]   = (hit && wr_op == OP_SETE) | (ie_q[k] & ~(hit && wr_op == OP_CLRE));
    assign cfg_d[k]  = (hit && wr_op == OP_CFG) ? (wr_data[DELEG] ? 3'd0 : wr_data[2:0])
                                                : cfg_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      lvl_q   <= '0;
      pend_q  <= '0;
      ie_q    <= '0;
      cfg_q   <= '0;
      dom_en  <= 1'b0;
    end else begin
      sync1_q <= src_in;
      sync2_q <= sync1_q;
      lvl_q   <= sync2_q;
      pend_q  <= pend_d;
      ie_q    <= ie_d;
      cfg_q   <= cfg_d;
      if (wr_en && wr_op == OP_DOM) dom_en <= wr_data[0];
    end
  end

  always_comb begin
    rd_cfg  = '0;
    rd_pend = 1'b0;
    rd_ie   = 1'b0;
    rd_in   = 1'b0;
    for (int k = 0; k < NSRC; k++)
      if (rd_num == NUMW'(k + 1)) begin
        rd_cfg  = {29'd0, cfg_q[k]};
        rd_pend = pend_q[k];
        rd_ie   = ie_q[k];
        rd_in   = lvl_q[k];
      end
  end
endmodule

module irq_sense_gateway_chk #(
  parameter int NSRC = 8,
  parameter int NUMW = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [2:0]           wr_op,
  input logic [NUMW-1:0]      wr_num,
  input logic                 wr_deleg,
  input logic                 dom_en,
  input logic                 fwd_valid,
  input logic [NUMW-1:0]      fwd_num,
  input logic [NSRC-1:0]      pend_q,
  input logic [NSRC-1:0]      ie_q,
  input logic [NSRC-1:0][2:0] cfg_q
);
  logic [NSRC-1:0] wsel, fsel, cfg_nz, lvl_mode;

  assign wsel = NSRC'(1) << (wr_num - NUMW'(1));
  assign fsel = NSRC'(1) << (fwd_num - NUMW'(1));

  for (genvar k = 0; k < NSRC; k++) begin : g_m
    assign cfg_nz[k]   = |cfg_q[k];
    assign lvl_mode[k] = (cfg_q[k][2:1] == 2'b11);
  end

  AST_FWD_DOMAIN: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> dom_en); // R8
  AST_FWD_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_en && |(pend_q & ie_q)) |-> fwd_valid); // R8
  AST_FWD_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> |(pend_q & ie_q & fsel)); // R9
  AST_FWD_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> ((pend_q & ie_q & (fsel - NSRC'(1))) == '0)); // R9
  AST_LEVEL_CLR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == 3'd2 && |(wsel & lvl_mode & pend_q)) |=> |(pend_q & $past(wsel))); // R7
  AST_DELEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == 3'd0 && wr_deleg && |wsel) |=> ~|(cfg_nz & $past(wsel))); // R3
  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q[0] && !cfg_nz[0] && !(wr_en && wr_op == 3'd1 && wr_num == NUMW'(1)))
      |=> !pend_q[0]); // R5
endmodule

bind irq_sense_gateway irq_sense_gateway_chk #(.NSRC(NSRC), .NUMW(NUMW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_num(wr_num),
  .wr_deleg(wr_data[10]), .dom_en(dom_en), .fwd_valid(fwd_valid), .fwd_num(fwd_num),
  .pend_q(pend_q), .ie_q(ie_q), .cfg_q(cfg_q)
);

// File: tb/test_irq_sense_gateway.sv
`timescale 1ns/1ps
module test_irq_sense_gateway;
  localparam int NSRC = 8;
  localparam int NUMW = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_in = '0;
  logic            wr_en = 1'b0;
  logic [2:0]      wr_op = '0;
  logic [NUMW-1:0] wr_num = '0;
  logic [31:0]     wr_data = '0;
  logic [NUMW-1:0] rd_num = '0;
  logic [31:0]     rd_cfg;
  logic            rd_pend, rd_ie, rd_in, dom_en, fwd_valid;
  logic [NUMW-1:0] fwd_num;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  irq_sense_gateway #(.NSRC(NSRC), .NUMW(NUMW)) i_irq_sense_gateway (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] op, input int num, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_op = op; wr_num = NUMW'(num); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int num);
    @(negedge clk);
    rd_num = NUMW'(num);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    wr(3'd5, 0, 32'd1);
    idle(NSRC + 3);
    wr(3'd5, 0, 32'd0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [7:0] pa [4];
    logic [7:0] pb [4];
    logic [7:0] pp [4];
    logic [7:0] pe [4];
    pa = '{8'h00, 8'hFF, 8'h0F, 8'hA5};
    pb = '{8'hFF, 8'h00, 8'h3C, 8'h5A};
    pp = '{8'hFF, 8'hA5, 8'h81, 8'hFF};
    pe = '{8'hFF, 8'h3C, 8'hFF, 8'h00};

    idle(3);
    rst_n = 1'b1;

    // R1 reset state, R2 out-of-range reads
    for (int n = 0; n < 32; n++) begin
      rd(n);
      chk("R1 cfg", rd_cfg, 0);
      chk("R1 pend", rd_pend, 0);
      chk("R1 ie", rd_ie, 0);
      chk("R1 in", rd_in, 0);
    end
    chk("R1 dom_en", dom_en, 0);
    chk("R1 fwd_valid", fwd_valid, 0);

    // R3 config write/readback, R2 ignored writes
    for (int n = 1; n <= NSRC; n++) wr(3'd0, n, 32'hFFFF_FBF8 | (n & 7));
    wr(3'd0, 0, 32'h3);
    for (int n = NSRC + 1; n < 32; n++) wr(3'd0, n, 32'h3);
    for (int n = 0; n < 32; n++) begin
      rd(n);
      chk((n >= 1 && n <= NSRC) ? "R3 cfg keep field" : "R2 cfg out of range",
          rd_cfg, (n >= 1 && n <= NSRC) ? (n & 7) : 0);
    end
    for (int n = 1; n <= NSRC; n++) wr(3'd0, n, 32'h0000_0407);
    for (int n = 1; n <= NSRC; n++) begin
      rd(n);
      chk("R3 delegate stores zero", rd_cfg, 0);
    end

    // enable all sources for draining; sweep every mode
    for (int n = 1; n <= NSRC; n++) wr(3'd3, n, 0);
    for (int m = 0; m < 8; m++) begin
      logic [NSRC-1:0] rest;
      rest = (m == 7) ? '1 : '0;
      for (int n = 1; n <= NSRC; n++) wr(3'd0, n, m);
      src_in = rest;
      idle(4);
      drain();
      wr(3'd1, 0, 0);
      wr(3'd1, NSRC + 1, 0);
      wr(3'd1, 31, 0);
      for (int n = 1; n <= NSRC; n++) begin
        rd(n);
        chk("R2 set to invalid number", rd_pend, 0);
      end
      for (int n = 1; n <= NSRC; n++) begin
        wr(3'd1, n, 0);
        rd(n);
        chk("R7 sw set", rd_pend, 1);
        wr(3'd2, n, 0);
        rd(n);
        chk("R7 sw clear", rd_pend, (m >= 6) ? 1 : 0);
      end
      for (int p = 0; p < 4; p++) begin
        src_in = rest;
        idle(4);
        drain();
        src_in = pa[p];
        idle(4);
        for (int n = 1; n <= NSRC; n++) wr(3'd2, n, 0);
        src_in = pb[p];
        idle(4);
        for (int n = 1; n <= NSRC; n++) begin
          logic a, b, e;
          a = pa[p][n-1];
          b = pb[p][n-1];
          case (m)
            4: e = ~a & b;
            5: e = a & ~b;
            6: e = a | b;
            7: e = ~a | ~b;
            default: e = 1'b0;
          endcase
          rd(n);
          chk((m == 4 || m == 5) ? "R4 edge sense" : "R5 level/inactive sense", rd_pend, e);
          chk("R6 stored input", rd_in, b);
        end
      end
    end

    // R7 enable set/clear, R2 ignored
    for (int n = 1; n <= NSRC; n++) wr(3'd4, n, 0);
    for (int n = 1; n <= NSRC; n += 2) wr(3'd3, n, 0);
    wr(3'd3, 0, 0);
    wr(3'd3, NSRC + 1, 0);
    for (int n = 0; n < 32; n++) begin
      rd(n);
      chk("R7 enable set/clear", rd_ie, (n >= 1 && n <= NSRC && (n % 2 == 1)) ? 1 : 0);
    end

    // R6 latency: pending after the third edge
    src_in = '0;
    for (int n = 1; n <= NSRC; n++) wr(3'd0, n, 4);
    idle(4);
    for (int n = 1; n <= NSRC; n++) wr(3'd2, n, 0);
    @(negedge clk);
    src_in[0] = 1'b1;
    rd_num = NUMW'(1);
    @(negedge clk); #1; chk("R6 latency edge1", rd_pend, 0);
    @(negedge clk); #1; chk("R6 latency edge2", rd_pend, 0);
    @(negedge clk); #1; chk("R6 latency edge3", rd_pend, 1);
    src_in = '0;
    idle(4);

    // R8 R9 R10 forwarding sweeps
    for (int p = 0; p < 4; p++) begin
      for (int n = 1; n <= NSRC; n++) begin
        wr(pe[p][n-1] ? 3'd3 : 3'd4, n, 0);
        wr(pp[p][n-1] ? 3'd1 : 3'd2, n, 0);
      end
      #1;
      chk("R8 no forward with domain off", fwd_valid, 0);
      wr(3'd5, 0, 32'd1);
      #1;
      for (int n = 1; n <= NSRC; n++) begin
        if (pp[p][n-1] && pe[p][n-1]) begin
          chk("R8 forward valid", fwd_valid, 1);
          chk("R9 lowest first", fwd_num, n);
          @(negedge clk); #1;
        end
      end
      chk("R8 forward idle", fwd_valid, 0);
      wr(3'd5, 0, 32'd0);
      for (int n = 1; n <= NSRC; n++) begin
        rd(n);
        chk("R10 consumed pending", rd_pend, pp[p][n-1] & ~pe[p][n-1]);
      end
    end

    // R10 collision: level-high source re-pends while consumed
    for (int n = 1; n <= NSRC; n++) begin
      wr(3'd2, n, 0);
      wr(3'd4, n, 0);
    end
    wr(3'd0, 2, 6);
    wr(3'd3, 2, 0);
    wr(3'd5, 0, 32'd1);
    src_in[1] = 1'b1;
    idle(3);
    #1;
    for (int c = 0; c < 5; c++) begin
      chk("R10 level re-pend valid", fwd_valid, 1);
      chk("R10 level re-pend num", fwd_num, 2);
      @(negedge clk); #1;
    end
    src_in[1] = 1'b0;
    idle(5);
    #1;
    chk("R10 level released", fwd_valid, 0);
    wr(3'd4, 2, 0);

    // R10 collision: rising edge lands in the consuming cycle
    wr(3'd3, 3, 0);
    @(negedge clk);
    src_in[2] = 1'b1;
    wr(3'd1, 3, 0);
    #1;
    chk("R10 edge collision first", fwd_valid, 1);
    chk("R10 edge collision first num", fwd_num, 3);
    @(negedge clk); #1;
    chk("R10 edge collision second", fwd_valid, 1);
    chk("R10 edge collision second num", fwd_num, 3);
    @(negedge clk); #1;
    chk("R10 edge collision done", fwd_valid, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule